// File: doc/BRIEF.md
# String Load/Store Sequencer

This block carries out multi-register string transfers between a single-request memory port and a 32-entry, 32-bit register file that sits outside the block. A command gives a start address, a byte count, a first register index and an operation code. The block steps through the transfer one access at a time. While at least four bytes remain it moves whole words, one register per word. It finishes any remainder of one to three bytes with single-byte accesses that pack into, or are taken from, the upper bytes of one last register. A load-multiple operation fills every register from the first index up to the last one with whole words.

An indexed form takes its byte count from a count register and names two address registers that the run must not cover. When the run would cover either of them, the block raises an invalid-form pulse and transfers nothing. When the block finishes a command it pulses `done` for one cycle and is ready for the next command.

The memory request side is valid/ready. The block holds a request (address, size, direction and write data) unchanged until `mem_req_ready` is sampled high with it. There is never more than one request outstanding. For a load, the block stays in a wait state until `mem_rsp_valid` arrives, and the memory may stall that response for any number of cycles. The command side is a plain strobe: `cmd_ready` is high only while the block is idle, and `cmd_valid` is acted on only then.

Top module: `strmove_seq`

## Requirements
- R1: While four or more bytes remain in a string operation, each access is a word access (`mem_req_byte`=0). Word data is big-endian, so the byte at the lowest address lands in bits 31:24. Each word moves exactly one register, and the address advances by 4 after each word.
- R2: In the string operations, the register index rises by one after each word and wraps from 31 back to 0.
- R3: For a load with 1 to 3 leftover bytes, the block issues byte accesses at consecutive addresses, using only `mem_rsp_rdata[7:0]`. The bytes go into bits 31:24, then 23:16, then 15:8 of the next register, and every other bit of that register ends as zero.
- R4: For a store with 1 to 3 leftover bytes, the block issues byte writes at consecutive addresses. Each carries, in `mem_req_wdata[7:0]`, bits 31:24, then 23:16, then 15:8 of the next register.
- R5: A string command with a byte count of zero makes no memory access and no register write, and it pulses `done` in the cycle after it is accepted.
- R6: For an indexed command (`cmd_indexed`=1) with a nonzero count, the block raises `exc_invalid` for one cycle instead of `done` when either condition holds: `cmd_ra`≠0 and rd < ra < rd+count, or rd < rb < rd+count (integer comparison of the register index against index plus byte count). It then makes no access and no register write.
- R7: Address arithmetic wraps modulo 2^32.
- R8: A request stays valid, with address, size, direction and write data stable, until it is accepted. For a load, no further request and no register write is made until the response arrives.
- R9: `done` is a one-cycle pulse in the cycle after the last access completes; a store completes on acceptance and a load on its response. `cmd_ready` is high exactly when the block is idle, including right after reset.
- R10: Load multiple (`cmd_op`=2'b10) loads whole words into registers rd through 31, in that order, and stops after register 31 without wrapping. It ignores the count and the indexed flag. Codes 2'b00 (load string) and 2'b01 (store string) select the string operations, and 2'b11 behaves as load string.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, taken while idle |
| cmd_ready | output | 1 | Block is idle |
| cmd_op | input | 2 | 00 load string, 01 store string, 10 load multiple, 11 load string |
| cmd_indexed | input | 1 | Indexed form: apply the protection check |
| cmd_addr | input | 32 | Start byte address |
| cmd_count | input | 7 | Byte count |
| cmd_rd | input | 5 | First register index |
| cmd_ra | input | 5 | Protected address register index (0 = none) |
| cmd_rb | input | 5 | Second protected register index |
| done | output | 1 | Completion pulse |
| exc_invalid | output | 1 | Invalid-form pulse |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_write | output | 1 | 1 = store |
| mem_req_byte | output | 1 | 1 = byte access, 0 = word |
| mem_req_addr | output | 32 | Request byte address |
| mem_req_wdata | output | 32 | Store data (byte in 7:0) |
| mem_rsp_valid | input | 1 | Load response valid |
| mem_rsp_rdata | input | 32 | Load data (byte in 7:0) |
| rf_raddr | output | 5 | Register file read index |
| rf_rdata | input | 32 | Register file read data (combinational) |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 5 | Register file write index |
| rf_wdata | output | 32 | Register file write data |

## Verification
The bench targets four kinds of case. The first is register runs that cross index 31; a design that failed to wrap would write or read past the file, or stop early. The second is start addresses just below 2^32, where a wide adder would carry out of the address. The third is byte tails of one, two and three bytes served with random upper response bits; a wrong lane order, a missing clear or unmasked upper bits would show up as wrong register contents. The fourth is indexed commands that sit just inside and just outside the protected ranges; an off-by-one bound would either transfer data it should have rejected or reject a legal run. Random memory stalls and delayed responses show whether requests stay stable and whether the block waits for each load.

// File: rtl/strmove_pkg.sv
package strmove_pkg;
  typedef enum logic [1:0] {
    OP_LSTR = 2'b00,
    OP_SSTR = 2'b01,
    OP_LMUL = 2'b10,
    OP_RSVD = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT
  } st_e;
endpackage

// File: rtl/strmove_guard.sv
// Range check for the indexed form: flags a run that covers a protected index.
module strmove_guard #(
  parameter int REG_W = 5,
  parameter int CNT_W = 7
) (
  input  logic [REG_W-1:0] rd,
  input  logic [REG_W-1:0] ra,
  input  logic [REG_W-1:0] rb,
  input  logic [CNT_W-1:0] cnt,
  output logic             hit
);
  localparam int SW = ((REG_W > CNT_W) ? REG_W : CNT_W) + 1;

  logic [SW-1:0] lo, hi, a_x, b_x;
  logic          hit_a, hit_b;

  assign lo    = SW'(rd);
  assign hi    = lo + SW'(cnt);
  assign a_x   = SW'(ra);
  assign b_x   = SW'(rb);
  assign hit_a = (ra != '0) && (lo < a_x) && (hi > a_x);
  assign hit_b = (lo < b_x) && (hi > b_x);
  assign hit   = hit_a | hit_b;
endmodule

// File: rtl/strmove_lane.sv
// Byte lane selection for the tail: packs a loaded byte into the accumulator
// and picks the outgoing byte for a store, high lane first.
module strmove_lane #(
  parameter int DATA_W = 32,
  parameter int POS_W  = 2
) (
  input  logic [DATA_W-1:0] acc_in,
  input  logic [7:0]        byte_in,
  input  logic [POS_W-1:0]  pos,
  input  logic [DATA_W-1:0] src,
  output logic [DATA_W-1:0] acc_out,
  output logic [7:0]        byte_out
);
  localparam int LANES = DATA_W / 8;

  always_comb begin
    acc_out  = acc_in;
    byte_out = '0;
    for (int i = 0; i < LANES; i++) begin
      if (pos == POS_W'(i)) begin
        acc_out[DATA_W-1-8*i -: 8] = acc_in[DATA_W-1-8*i -: 8] | byte_in;
        byte_out                   = src[DATA_W-1-8*i -: 8];
      end
    end
  end
endmodule

// File: rtl/strmove_step.sv
// Next address: word or byte stride, wrapping at the address width.
module strmove_step #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              word,
  output logic [ADDR_W-1:0] addr_out
);
  localparam int STRIDE = DATA_W / 8;

  assign addr_out = addr_in + (word ? ADDR_W'(STRIDE) : ADDR_W'(1));
endmodule

// File: rtl/strmove_seq.sv
module strmove_seq
  import strmove_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 7,
  parameter int REG_N  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic              cmd_indexed,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [CNT_W-1:0]  cmd_count,
  input  logic [$clog2(REG_N)-1:0] cmd_rd,
  input  logic [$clog2(REG_N)-1:0] cmd_ra,
  input  logic [$clog2(REG_N)-1:0] cmd_rb,
  output logic              done,
  output logic              exc_invalid,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic              mem_req_byte,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata,
  output logic [$clog2(REG_N)-1:0] rf_raddr,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic              rf_we,
  output logic [$clog2(REG_N)-1:0] rf_waddr,
  output logic [DATA_W-1:0] rf_wdata
);
  localparam int REG_W = $clog2(REG_N);
  localparam int BYTES = DATA_W / 8;
  localparam int POS_W = $clog2(BYTES);

  st_e               st_q;
  op_e               op_q, cmd_op_e;
  logic [ADDR_W-1:0] addr_q, addr_nx;
  logic [CNT_W-1:0]  rem_q;
  logic [REG_W-1:0]  reg_q;
  logic [POS_W-1:0]  pos_q;
  logic [DATA_W-1:0] acc_q, acc_nx;
  logic [7:0]        st_byte;
  logic              done_q, exc_q;
  logic              guard_hit;
  logic              word_ph, is_store, is_lmul, step, last;

  assign cmd_op_e = op_e'(cmd_op);
  assign is_store = (op_q == OP_SSTR);
  assign is_lmul  = (op_q == OP_LMUL);
  assign word_ph  = is_lmul || (rem_q >= CNT_W'(BYTES));

  strmove_guard #(.REG_W(REG_W), .CNT_W(CNT_W)) u_guard (
    .rd(cmd_rd), .ra(cmd_ra), .rb(cmd_rb), .cnt(cmd_count), .hit(guard_hit)
  );

  strmove_lane #(.DATA_W(DATA_W), .POS_W(POS_W)) u_lane (
    .acc_in(acc_q), .byte_in(mem_rsp_rdata[7:0]), .pos(pos_q), .src(rf_rdata),
    .acc_out(acc_nx), .byte_out(st_byte)
  );

  strmove_step #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_step (
    .addr_in(addr_q), .word(word_ph), .addr_out(addr_nx)
  );

  // An access completes on acceptance (store) or on its response (load).
  assign step = is_store ? ((st_q == ST_REQ) && mem_req_ready)
                         : ((st_q == ST_WAIT) && mem_rsp_valid);
  assign last = is_lmul ? (reg_q == REG_W'(REG_N - 1))
                        : (word_ph ? (rem_q == CNT_W'(BYTES)) : (rem_q == CNT_W'(1)));

  assign cmd_ready     = (st_q == ST_IDLE);
  assign done          = done_q;
  assign exc_invalid   = exc_q;
  assign mem_req_valid = (st_q == ST_REQ);
  assign mem_req_write = is_store;
  assign mem_req_byte  = !word_ph;
  assign mem_req_addr  = addr_q;
  assign mem_req_wdata = word_ph ? rf_rdata : DATA_W'(st_byte);
  assign rf_raddr      = reg_q;
  assign rf_we         = (st_q == ST_WAIT) && mem_rsp_valid;
  assign rf_waddr      = reg_q;
  assign rf_wdata      = word_ph ? mem_rsp_rdata : acc_nx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_LSTR;
      addr_q <= '0;
      rem_q  <= '0;
      reg_q  <= '0;
      pos_q  <= '0;
      acc_q  <= '0;
      done_q <= 1'b0;
      exc_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      exc_q  <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (cmd_valid) begin
            op_q   <= cmd_op_e;
            addr_q <= cmd_addr;
            rem_q  <= cmd_count;
            reg_q  <= cmd_rd;
            pos_q  <= '0;
            acc_q  <= '0;
            if (cmd_op_e == OP_LMUL)          st_q   <= ST_REQ;
            else if (cmd_count == '0)         done_q <= 1'b1;
            else if (cmd_indexed && guard_hit) exc_q <= 1'b1;
            else                              st_q   <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (mem_req_ready && !is_store) st_q <= ST_WAIT;
        end
        default: ;
      endcase
      if (step) begin
        addr_q <= addr_nx;
        if (word_ph) begin
          rem_q <= rem_q - CNT_W'(BYTES);
          reg_q <= reg_q + REG_W'(1);
          pos_q <= '0;
        end else begin
          rem_q <= rem_q - CNT_W'(1);
          pos_q <= pos_q + POS_W'(1);
          acc_q <= acc_nx;
        end
        if (last) begin
          st_q   <= ST_IDLE;
          done_q <= 1'b1;
        end else begin
          st_q   <= ST_REQ;
        end
      end
    end
  end

  // R8: a stalled request keeps every field steady
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr) &&
      $stable(mem_req_byte) && $stable(mem_req_write) && $stable(mem_req_wdata)));

  // R8: no register write while a request is being offered
  assert_one_outstanding_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> !mem_req_valid);

  // R6: exception and completion never coincide
  assert_done_exc_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && exc_invalid));

  // R6: an exception only follows directly on an accepted command
  assert_exc_after_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exc_invalid |-> $past(cmd_valid && cmd_ready));

  // R9: no new command is taken while an access is pending
  assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !cmd_ready);

  // R9: done follows a completed access or a just-accepted empty command
  assert_done_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past((mem_req_valid && mem_req_ready) || mem_rsp_valid || (cmd_valid && cmd_ready)));
endmodule

// File: tb/strmove_seq_test.sv
module strmove_seq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid, cmd_ready, cmd_indexed;
  logic [1:0]  cmd_op;
  logic [31:0] cmd_addr;
  logic [6:0]  cmd_count;
  logic [4:0]  cmd_rd, cmd_ra, cmd_rb;
  logic        done, exc_invalid;
  logic        mem_req_valid, mem_req_ready, mem_req_write, mem_req_byte;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_rdata;
  logic [4:0]  rf_raddr, rf_waddr;
  logic [31:0] rf_rdata, rf_wdata;
  logic        rf_we;

  always #5 clk = ~clk;

  strmove_seq uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_indexed(cmd_indexed), .cmd_addr(cmd_addr),
    .cmd_count(cmd_count), .cmd_rd(cmd_rd), .cmd_ra(cmd_ra), .cmd_rb(cmd_rb),
    .done(done), .exc_invalid(exc_invalid), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
    .mem_req_byte(mem_req_byte), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
  );

  logic [7:0]  mem [256];
  logic [31:0] rf [32];
  logic [7:0]  exp_mem [256];
  logic [31:0] exp_rf [32];
  int          checks = 0, fails = 0;
  int          acc_count, wr_count;
  logic [31:0] mon_addr;
  int          mon_rem;
  bit          mon_lmul;
  bit          pend;
  int          dly;
  logic [31:0] pdata;
  bit          finished = 0;

  assign rf_rdata = rf[rf_raddr];

  always @(posedge clk) begin
    if (rf_we) begin
      rf[rf_waddr] <= rf_wdata;
      wr_count     <= wr_count + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] rdw(input logic [31:0] a);
    logic [7:0] i;
    i = a[7:0];
    return {mem[i], mem[8'(i + 1)], mem[8'(i + 2)], mem[8'(i + 3)]};
  endfunction

  // Memory side: ready stalls, delayed load responses, access monitor
  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_rdata = '0;
    pend = 0;
    dly  = 0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (dly == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_rdata = pdata;
          pend = 0;
        end else dly--;
      end
      mem_req_ready = ($urandom_range(0, 3) != 0);
      if (mem_req_valid && mem_req_ready) begin
        bit bexp;
        bexp = !mon_lmul && (mon_rem < 4);
        // R1 R3 R4 R7: address sequence and access size
        chk(mem_req_addr == mon_addr && mem_req_byte == bexp, "R1 R7",
            "access address/size", mem_req_addr, mon_addr);
        acc_count++;
        if (mem_req_write) begin
          if (mem_req_byte) mem[mem_req_addr[7:0]] = mem_req_wdata[7:0];
          else begin
            for (int k = 0; k < 4; k++)
              mem[8'(mem_req_addr[7:0] + k)] = mem_req_wdata[31-8*k -: 8];
          end
        end else begin
          pdata = mem_req_byte ? {$urandom_range(0, 32'hffffff), mem[mem_req_addr[7:0]]}
                               : rdw(mem_req_addr);
          pend = 1;
          dly  = $urandom_range(0, 2);
        end
        mon_addr = mon_addr + (mem_req_byte ? 32'd1 : 32'd4);
        mon_rem  = mon_rem - (mem_req_byte ? 1 : 4);
      end
    end
  end

  task automatic model(input logic [1:0] op, input logic [31:0] addr,
                       input int cnt, input int rd);
    logic [31:0] a, v;
    int r, n;
    a = addr; r = rd; n = cnt;
    if (op == 2'b10) begin
      for (int q = rd; q < 32; q++) begin
        exp_rf[q] = rdw(a);
        a = a + 4;
      end
    end else begin
      while (n >= 4) begin
        if (op == 2'b01) begin
          for (int k = 0; k < 4; k++) exp_mem[8'(a[7:0] + k)] = rf[r][31-8*k -: 8];
        end else exp_rf[r] = rdw(a);
        r = (r + 1) % 32; a = a + 4; n = n - 4;
      end
      if (n > 0) begin
        v = '0;
        for (int k = 0; k < n; k++) begin
          if (op == 2'b01) exp_mem[a[7:0]] = rf[r][31-8*k -: 8];
          else v = v | ({24'b0, mem[a[7:0]]} << (24 - 8*k));
          a = a + 1;
        end
        if (op != 2'b01) exp_rf[r] = v;
      end
    end
  endtask

  task automatic run_cmd(input logic [1:0] op, input bit idx, input logic [31:0] addr,
                         input int cnt, input int rd, input int ra, input int rb,
                         input string tag);
    bit exp_exc;
    int exp_acc, n, mism;
    exp_exc = (op != 2'b10) && idx && (cnt != 0) &&
              (((ra != 0) && (rd < ra) && (rd + cnt > ra)) || ((rd < rb) && (rd + cnt > rb)));
    for (int i = 0; i < 32; i++) exp_rf[i] = rf[i];
    for (int i = 0; i < 256; i++) exp_mem[i] = mem[i];
    if (op == 2'b10) exp_acc = 32 - rd;
    else if (exp_exc) exp_acc = 0;
    else exp_acc = cnt / 4 + cnt % 4;
    if (!exp_exc) model(op, addr, cnt, rd);
    mon_addr = addr; mon_rem = cnt; mon_lmul = (op == 2'b10);
    acc_count = 0; wr_count = 0;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R9", "ready while idle", 32'(cmd_ready), 32'd1);
    cmd_valid = 1'b1; cmd_op = op; cmd_indexed = idx; cmd_addr = addr;
    cmd_count = 7'(cnt); cmd_rd = 5'(rd); cmd_ra = 5'(ra); cmd_rb = 5'(rb);
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 0;
    while (!(done || exc_invalid) && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(n < 5000, tag, "completion seen", 32'(n), 32'd0);
    chk(exc_invalid == exp_exc && done == !exp_exc, "R6 R9", "done/exc outcome",
        {30'b0, exc_invalid, done}, {30'b0, exp_exc, !exp_exc});
    if (cnt == 0 && op != 2'b10)
      chk(n == 0, "R5", "done right after accept", 32'(n), 32'd0);
    @(negedge clk);
    chk(!done && !exc_invalid && cmd_ready, "R9", "pulse is one cycle",
        {29'b0, cmd_ready, exc_invalid, done}, 32'd4);
    chk(acc_count == exp_acc, tag, "access count", 32'(acc_count), 32'(exp_acc));
    if (exp_exc || (cnt == 0 && op != 2'b10))
      chk(wr_count == 0, tag, "no register write", 32'(wr_count), 32'd0);
    mism = 0;
    for (int i = 0; i < 32; i++) if (rf[i] !== exp_rf[i]) begin
      if (mism == 0) chk(1'b0, tag, $sformatf("reg %0d", i), rf[i], exp_rf[i]);
      mism++;
    end
    for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) begin
      if (mism == 0) chk(1'b0, tag, $sformatf("mem %0d", i), 32'(mem[i]), 32'(exp_mem[i]));
      mism++;
    end
    if (mism == 0) chk(1'b1, tag, "state", 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_indexed = 1'b0;
    cmd_addr = '0; cmd_count = '0; cmd_rd = '0; cmd_ra = '0; cmd_rb = '0;
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    for (int i = 0; i < 32; i++) rf[i] = $urandom;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready && !mem_req_valid && !done && !exc_invalid && !rf_we, "R9",
        "reset state", {27'b0, cmd_ready, mem_req_valid, done, exc_invalid, rf_we}, 32'h10);

    run_cmd(2'b00, 0, 32'h0000_0040, 16, 3, 0, 0, "R1");        // words only
    run_cmd(2'b00, 0, 32'h0000_0081, 1, 7, 0, 0, "R3");         // 1-byte tail
    run_cmd(2'b00, 0, 32'h0000_0091, 6, 9, 0, 0, "R3");         // 2-byte tail
    run_cmd(2'b11, 0, 32'h0000_00a3, 7, 12, 0, 0, "R3");        // 3-byte tail, code 11
    run_cmd(2'b01, 0, 32'h0000_0010, 3, 5, 0, 0, "R4");         // store tail only
    run_cmd(2'b01, 0, 32'h0000_0020, 9, 20, 0, 0, "R4");
    run_cmd(2'b00, 0, 32'h0000_0030, 14, 30, 0, 0, "R2");       // wraps 31 -> 0
    run_cmd(2'b01, 0, 32'h0000_0060, 12, 31, 0, 0, "R2");
    run_cmd(2'b00, 0, 32'hffff_fffa, 11, 4, 0, 0, "R7");        // address wrap
    run_cmd(2'b01, 0, 32'hffff_fffd, 6, 8, 0, 0, "R7");
    run_cmd(2'b00, 1, 32'h0000_0050, 0, 6, 7, 8, "R5");         // indexed zero count
    run_cmd(2'b01, 0, 32'h0000_0050, 0, 6, 0, 0, "R5");
    run_cmd(2'b00, 1, 32'h0000_0050, 3, 4, 6, 0, "R6");         // ra covered
    run_cmd(2'b00, 1, 32'h0000_0050, 3, 4, 0, 5, "R6");         // rb covered
    run_cmd(2'b00, 1, 32'h0000_0050, 2, 4, 6, 6, "R6");         // rd+cnt == ra: legal
    run_cmd(2'b00, 1, 32'h0000_0050, 5, 4, 0, 4, "R6");         // rb == rd: legal
    run_cmd(2'b10, 1, 32'h0000_0070, 0, 27, 28, 29, "R10");     // load multiple
    run_cmd(2'b10, 0, 32'hffff_fff8, 9, 31, 0, 0, "R10");

    for (int t = 0; t < 40; t++) begin
      logic [1:0]  op;
      logic [31:0] a;
      op = 2'($urandom_range(0, 2));
      a  = ($urandom_range(0, 3) == 0) ? (32'hffff_ffe0 | 32'($urandom_range(0, 31)))
                                       : $urandom;
      run_cmd(op, 1'($urandom), a, $urandom_range(0, 40), $urandom_range(0, 31),
              $urandom_range(0, 31), $urandom_range(0, 31),
              (op == 2'b10) ? "R10" : ((op == 2'b01) ? "R4" : "R3"));
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule